// File: doc/BRIEF.md
# Signed Sequential Divider, Non-Restoring, Four-Quadrant

This block divides a 2W-bit two's-complement dividend by a W-bit two's-complement divisor (W = 16 by default). It returns a W-bit quotient that is truncated toward zero, a W-bit remainder, an overflow flag and a divide-by-zero flag. The core never turns negative operands positive. Each step takes the signs of the partial remainder and the divisor, picks add or subtract, and records a quotient digit of +1 or -1. The digits are turned into binary at the end. A fix-up step then puts the remainder's sign in line with the dividend.

A one-cycle `start` pulse loads the operands while the block is idle. `busy` stays high until the single-cycle `done`. Three overflow checks run at different stages. The early check on the top two dividend bits runs in the setup cycle, and is skipped when the divisor is the most negative value. The band check on the upper dividend half runs in the first iteration cycle. The range check on the corrected quotient runs after the fix-up. A quotient of exactly -2^(W-1) is a valid result. When overflow is flagged, the quotient and remainder outputs carry no meaning.

Top module: `sdiv_nr`

The sequencer has six states:
- `ST_IDLE` moves to `ST_SETUP` on `start`.
- `ST_SETUP` moves to `ST_FINISH` on a zero divisor or an early overflow, and to `ST_ITER` otherwise.
- `ST_ITER` runs W cycles, then moves to `ST_FIX`. In its first cycle it moves to `ST_FINISH` instead if the band check fails.
- `ST_FIX` moves to `ST_RANGE`.
- `ST_RANGE` moves to `ST_FINISH`.
- `ST_FINISH` raises `done` and returns to `ST_IDLE`.

## Requirements
- R1: After reset, busy_o, done_o, ovf_o and dz_o are 0, and quot_o and rem_o are zero.
- R2: Timing is counted from the clock edge that samples start_i while the block is idle. A division that runs to the end raises done_o in the cycle that follows the (W+3)-th edge after it. done_o lasts exactly one cycle, and busy_o is 1 from that first edge through the done_o cycle, then returns to 0.
- R3: When ovf_o = 0, the results satisfy dividend = quot_o*divisor + rem_o. The remainder is zero or has the sign of the dividend, and |rem_o| < |divisor|. This holds for all four sign combinations.
- R4: A quotient of exactly -32768 sets ovf_o = 0 and is returned correctly. Examples: (2^30+5)/-32768 gives -32768 r 5, and -65537/2 gives -32768 r -1.
- R5: With divisor -32768 (bit pattern 0x8000) and a dividend whose low 16 bits are zero, the results are exact. Example: 131072/-32768 gives -4 r 0.
- R6: A zero divisor sets ovf_o = 1 and dz_o = 1, and done_o follows 1 edge after the start edge.
- R7: When the divisor is not 0x8000 and dividend bits 31 and 30 differ, ovf_o = 1, dz_o = 0 and done_o follows 1 edge after the start edge. With divisor 0x8000 this check does not apply. Example: 0x40000000/-32768 gives -32768 r 0 with no overflow.
- R8: Let H be the upper 16 dividend bits taken as a signed value. If the R6 and R7 checks pass and H lies outside [-|divisor|, |divisor|-1], then ovf_o = 1 and done_o follows 2 edges after the start edge.
- R9: Any other division whose truncated quotient lies outside [-32768, 32767] runs to the end with the R2 timing and sets ovf_o = 1. Examples: 65535/-1 and 32768/1.
- R10: A start_i pulse while busy_o = 1 is ignored. The running division completes with its own operands and its own timing, and no new division begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division; sampled only when idle |
| dividend_i | input | 2W | Signed dividend, captured with start_i |
| divisor_i | input | W | Signed divisor, captured with start_i |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | Results valid, one-cycle pulse |
| quot_o | output | W | Signed quotient |
| rem_o | output | W | Signed remainder |
| ovf_o | output | 1 | Quotient not representable or divisor zero |
| dz_o | output | 1 | Divisor was zero |

## Verification
Any fault in the digit-select sign test or in the shift order of the dividend's low half corrupts every later partial remainder. Such a fault shows up at the first `done_o` as a quotient and remainder that break dividend = q*d + r. A wrong iteration count or a wrong abort route moves `done_o` and the fall of `busy_o` by at least one cycle, which a per-cycle comparison of the handshake catches at once. A misplaced exemption for the most negative divisor, or a range check that is off by one, shows up only on the -32768 quotient and late-overflow vectors. For that reason those vectors are driven explicitly rather than left to chance.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX,
        ST_RANGE,
        ST_FINISH
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_fsm.sv
module sdiv_fsm
    import sdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        abort_setup_i,
    input  logic        abort_iter_i,
    output sdiv_state_e state_o,
    output logic        load_o,
    output logic        first_o,
    output logic        step_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] CNT_TOP = CW'(W - 1);

    sdiv_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic first;

    assign first = (state == ST_ITER) && (cnt == CNT_TOP);

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SETUP) begin
                cnt <= CNT_TOP;
            end else if (state == ST_ITER && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = start_i ? ST_SETUP : ST_IDLE;
            ST_SETUP:  nxt = abort_setup_i ? ST_FINISH : ST_ITER;
            ST_ITER: begin
                if (first && abort_iter_i) nxt = ST_FINISH;
                else if (cnt == '0)        nxt = ST_FIX;
                else                       nxt = ST_ITER;
            end
            ST_FIX:    nxt = ST_RANGE;
            ST_RANGE:  nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state_o = state;
        first_o = first;
        load_o  = (state == ST_IDLE) && start_i;
        step_o  = (state == ST_ITER) && !(first && abort_iter_i);
        busy_o  = (state != ST_IDLE);
        done_o  = (state == ST_FINISH);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> busy_o); // R2
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state == ST_IDLE)); // R2
    AST_FIX_AFTER_ITER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> ($past(state) == ST_ITER)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER && start_i && !first) |=> (state != ST_SETUP)); // R10

endmodule

// File: rtl/sdiv_guard.sv
module sdiv_guard #(
    parameter int W = 16
) (
    input  logic [1:0]   dvd_top_i,
    input  logic [W-1:0] dsr_i,
    input  logic [W+1:0] prem_i,
    output logic         zero_o,
    output logic         early_o,
    output logic         band_out_o,
    output logic [W:0]   dmag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   dsx;
    logic [W+1:0] mag2;
    logic         min_dsr;

    always_comb begin
        zero_o  = (dsr_i == '0);
        min_dsr = (dsr_i == MOST_NEG);
        early_o = !min_dsr && (dvd_top_i[1] != dvd_top_i[0]);
        dsx     = {dsr_i[W-1], dsr_i};
        dmag_o  = dsr_i[W-1] ? (~dsx + 1'b1) : dsx;
        mag2    = {1'b0, dmag_o};
        band_out_o = ($signed(prem_i) < $signed(-mag2)) ||
                     ($signed(prem_i) >= $signed(mag2));
    end

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int W = 16
) (
    input  logic [W+1:0] prem_i,
    input  logic [W-1:0] dsr_i,
    input  logic         bit_i,
    output logic [W+1:0] prem_o,
    output logic         qbit_o
);
    logic [W+1:0] dext, shifted;
    logic         same;

    always_comb begin
        dext    = {{2{dsr_i[W-1]}}, dsr_i};
        shifted = {prem_i[W:0], bit_i};
        same    = (prem_i[W+1] == dsr_i[W-1]);
        prem_o  = same ? (shifted - dext) : (shifted + dext);
        qbit_o  = same;
    end

endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
    parameter int W = 16
) (
    input  logic [W+1:0] prem_i,
    input  logic [W-1:0] cbits_i,
    input  logic [W-1:0] dsr_i,
    input  logic [W:0]   dmag_i,
    input  logic         dvd_neg_i,
    output logic [W+1:0] q_o,
    output logic [W+1:0] r_o
);
    logic [W+1:0] qraw, dext, neg_mag;
    logic         p_zero, p_full, need, same;

    always_comb begin
        // digits of +1/-1 map to 2*C - (2^W - 1)
        qraw    = {1'b0, cbits_i, 1'b1} - {2'b01, {W{1'b0}}};
        dext    = {{2{dsr_i[W-1]}}, dsr_i};
        neg_mag = -{1'b0, dmag_i};
        p_zero  = (prem_i == '0);
        p_full  = (prem_i == neg_mag);
        need    = p_full || (!p_zero && (prem_i[W+1] != dvd_neg_i));
        same    = (prem_i[W+1] == dsr_i[W-1]);
        if (!need) begin
            q_o = qraw;
            r_o = prem_i;
        end else if (same) begin
            q_o = qraw + 1'b1;
            r_o = prem_i - dext;
        end else begin
            q_o = qraw - 1'b1;
            r_o = prem_i + dext;
        end
    end

endmodule

// File: rtl/sdiv_nr.sv
module sdiv_nr
    import sdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [W-1:0]   quot_o,
    output logic [W-1:0]   rem_o,
    output logic           ovf_o,
    output logic           dz_o
);
    localparam int DW = 2 * W;
    localparam int PW = W + 2;

    sdiv_state_e state;
    logic load, first, step;
    logic zero, early, band_out, qbit, fits;
    logic [W:0]    dmag;
    logic [PW-1:0] prem_nxt, q_fix, r_fix;

    logic [1:0]    dvd_top_q;
    logic [W-1:0]  dsr_q, lo_q, cbits_q, quot_q, rem_q;
    logic [PW-1:0] prem_q, qw_q;
    logic          ovf_q, dz_q;

    sdiv_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .abort_setup_i(zero | early),
        .abort_iter_i (band_out),
        .state_o      (state),
        .load_o       (load),
        .first_o      (first),
        .step_o       (step),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    sdiv_guard #(.W(W)) u_guard (
        .dvd_top_i (dvd_top_q),
        .dsr_i     (dsr_q),
        .prem_i    (prem_q),
        .zero_o    (zero),
        .early_o   (early),
        .band_out_o(band_out),
        .dmag_o    (dmag)
    );

    sdiv_step #(.W(W)) u_step (
        .prem_i(prem_q),
        .dsr_i (dsr_q),
        .bit_i (lo_q[W-1]),
        .prem_o(prem_nxt),
        .qbit_o(qbit)
    );

    sdiv_fixup #(.W(W)) u_fix (
        .prem_i   (prem_q),
        .cbits_i  (cbits_q),
        .dsr_i    (dsr_q),
        .dmag_i   (dmag),
        .dvd_neg_i(dvd_top_q[1]),
        .q_o      (q_fix),
        .r_o      (r_fix)
    );

    assign fits = (qw_q[PW-1:W-1] == 3'b000) || (qw_q[PW-1:W-1] == 3'b111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_top_q <= '0;
            dsr_q     <= '0;
            lo_q      <= '0;
            cbits_q   <= '0;
            prem_q    <= '0;
            qw_q      <= '0;
            quot_q    <= '0;
            rem_q     <= '0;
            ovf_q     <= 1'b0;
            dz_q      <= 1'b0;
        end else begin
            if (load) begin
                dvd_top_q <= dividend_i[DW-1:DW-2];
                dsr_q     <= divisor_i;
                prem_q    <= {{2{dividend_i[DW-1]}}, dividend_i[DW-1:W]};
                lo_q      <= dividend_i[W-1:0];
                cbits_q   <= '0;
                ovf_q     <= 1'b0;
                dz_q      <= 1'b0;
            end
            if (state == ST_SETUP && (zero || early)) begin
                ovf_q <= 1'b1;
                dz_q  <= zero;
            end
            if (first && band_out) begin
                ovf_q <= 1'b1;
            end
            if (step) begin
                prem_q  <= prem_nxt;
                lo_q    <= {lo_q[W-2:0], 1'b0};
                cbits_q <= {cbits_q[W-2:0], qbit};
            end
            if (state == ST_FIX) begin
                prem_q <= r_fix;
                qw_q   <= q_fix;
            end
            if (state == ST_RANGE) begin
                quot_q <= qw_q[W-1:0];
                rem_q  <= prem_q[W-1:0];
                ovf_q  <= !fits;
            end
        end
    end

    assign quot_o = quot_q;
    assign rem_o  = rem_q;
    assign ovf_o  = ovf_q;
    assign dz_o   = dz_q;

    // checking helpers
    logic [W:0]    rem_abs;
    logic [PW-1:0] band_hi;
    logic          prem_in_band;
    always_comb begin
        rem_abs      = rem_o[W-1] ? -{1'b1, rem_o} : {1'b0, rem_o};
        band_hi      = {1'b0, dmag};
        prem_in_band = ($signed(prem_q) >= $signed(-band_hi)) &&
                       ($signed(prem_q) <  $signed(band_hi));
    end

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && zero) |=> (done_o && dz_o && ovf_o)); // R6
    AST_EARLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP && !zero && early) |=> (done_o && ovf_o && !dz_o)); // R7
    AST_BAND_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (first && band_out) |=> (done_o && ovf_o)); // R8
    AST_PREM_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> prem_in_band); // R8
    AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o && rem_o != '0) |-> (rem_o[W-1] == dvd_top_q[1])); // R3
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> (rem_abs < dmag)); // R3

endmodule

// File: tb/tb_sdiv_nr.sv
`timescale 1ns/1ps
module tb_sdiv_nr;
    localparam int W = 16;
    localparam int FULL_LAT = W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2*W-1:0] dividend = '0;
    logic [W-1:0]   divisor = '0;
    logic busy, done, ovf, dz;
    logic [W-1:0] quot, rem;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    sdiv_nr #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dividend_i(dividend), .divisor_i(divisor),
        .busy_o(busy), .done_o(done), .quot_o(quot), .rem_o(rem),
        .ovf_o(ovf), .dz_o(dz)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // mid > 0: pulse start with other operands mid cycles into the run
    task automatic run_div(input logic [31:0] a, input logic [15:0] b,
                           input string rq, input int mid);
        longint nn, dd, q, r, hi, dm;
        int lat;
        bit ev, ez;
        nn = longint'($signed(a));
        dd = longint'($signed(b));
        q = 0; r = 0; ev = 0; ez = 0;
        if (dd == 0) begin
            lat = 1; ev = 1; ez = 1;
        end else if (dd != -32768 && a[31] != a[30]) begin
            lat = 1; ev = 1;
        end else begin
            hi = nn >>> 16;
            dm = (dd < 0) ? -dd : dd;
            if (hi < -dm || hi >= dm) begin
                lat = 2; ev = 1;
            end else begin
                lat = FULL_LAT;
                q = nn / dd;
                r = nn % dd;
                ev = (q < -32768) || (q > 32767);
            end
        end
        @(negedge clk);
        chk(!busy && !done, "R2", "idle busy/done", {busy, done}, 0);
        dividend = a; divisor = b; start = 1'b1;
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            if (i == 0) start = 1'b0;
            if (mid > 0 && i == mid) begin
                start = 1'b1; dividend = ~a; divisor = b + 16'd3;
            end
            if (mid > 0 && i == mid + 1) start = 1'b0;
            chk(busy === 1'b1, rq, "busy", busy, 1);
            chk(done === (i == lat), rq, "done timing", done, (i == lat));
            if (i == lat) begin
                chk(ovf === ev, rq, "ovf", ovf, ev);
                chk(dz === ez, rq, "dz", dz, ez);
                if (!ev) begin
                    chk(longint'($signed(quot)) == q, rq, "quotient",
                        longint'($signed(quot)), q);
                    chk(longint'($signed(rem)) == r, rq, "remainder",
                        longint'($signed(rem)), r);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done, "R1", "busy/done", {busy, done}, 0);
        chk(!ovf && !dz, "R1", "flags", {ovf, dz}, 0);
        chk(quot == '0 && rem == '0, "R1", "results", quot, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R1", "after release", {busy, done}, 0);

        // R3 four sign quadrants
        run_div(32'd100, 16'd7, "R3", 0);
        run_div(-32'sd100, 16'd7, "R3", 0);
        run_div(32'd100, -16'sd7, "R3", 0);
        run_div(-32'sd100, -16'sd7, "R3", 0);
        run_div(32'd7, 16'd100, "R3", 0);
        run_div(-32'sd7, 16'd100, "R3", 0);
        run_div(32'd1_000_000, 16'd1000, "R3", 0);
        run_div(-32'sd1_000_000, -16'sd1000, "R3", 0);
        // R4 quotient of -32768
        run_div(32'h4000_0005, 16'h8000, "R4", 0);
        run_div(-32'sd65537, 16'd2, "R4", 0);
        run_div(32'd32768, -16'sd1, "R4", 0);
        // R5 most negative divisor with clear low half
        run_div(32'h0002_0000, 16'h8000, "R5", 0);
        run_div(32'hFFFE_0000, 16'h8000, "R5", 0);
        run_div(32'h3FFF_0000, 16'h8000, "R5", 0);
        run_div(32'h0000_0000, 16'h8000, "R5", 0);
        // R6 divide by zero
        run_div(32'd1234, 16'd0, "R6", 0);
        run_div(32'd0, 16'd0, "R6", 0);
        // R7 early check and its exemption
        run_div(32'h4000_0000, 16'd3, "R7", 0);
        run_div(32'h8000_0000, 16'd5, "R7", 0);
        run_div(32'h4000_0000, 16'h8000, "R7", 0);
        // R8 band check on the first iteration
        run_div(32'h0005_0000, 16'd3, "R8", 0);
        run_div(32'hFFFC_0000, 16'd2, "R8", 0);
        // R9 late overflow
        run_div(32'd32768, 16'd1, "R9", 0);
        run_div(32'd65535, -16'sd1, "R9", 0);
        run_div(32'hC000_0000, 16'h8000, "R9", 0);
        // R10 start while busy
        run_div(32'd5000, 16'd37, "R10", 3);
        run_div(-32'sd77777, 16'd91, "R10", 10);
        // structured and raw random vectors
        for (int k = 0; k < 250; k++) begin
            logic [31:0] x, y;
            longint dd, qv, rv, nn;
            x = next_rand();
            y = next_rand();
            dd = longint'($signed(x[15:0]));
            if (dd == 0) dd = 1;
            qv = longint'($signed(y[15:0]));
            rv = longint'(y[31:16]) % ((dd < 0) ? -dd : dd);
            if (x[16]) rv = -rv;
            nn = qv * dd + rv;
            if (k % 4 == 3) run_div(next_rand(), x[15:0], "R3", 0);
            else            run_div(nn[31:0], dd[15:0], "R3", 0);
        end
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule